// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

The block takes a 4-bit encoded external interrupt level and turns it into per-source assert lines for a chain of fifteen level-triggered sources. A level of zero requests nothing; any other value selects exactly one chain slot, and that slot is driven asserted while every other slot is driven deasserted. Level 15 carries the highest priority and maps to slot 0; level 1 is the lowest and maps to slot 14. The slot index is the level inverted bitwise (level XOR 15).

The level is registered every clock. From the registered level the block computes a one-hot target and compares it against the per-slot asserted state it holds. Every disagreement produces a one-cycle event pulse toward a downstream pending aggregator: an assert pulse when a slot rises, a deassert pulse when it falls. When a slot is newly asserted and the aggregator reports that slot's enable count as zero, an enable pulse is issued together with the assert pulse, so a slot selected by level is never left masked. Input synchronisation and the aggregator are outside the block.

Top module: `irl_level_decoder`

## Requirements
- R1: While rst_ni is low and on the first cycles after its release, asrt_o, ast_pulse_o, deast_pulse_o and en_pulse_o are all zero.
- R2: When level_i holds a nonzero value L, asrt_o becomes one-hot with bit (L XOR 15) set, on the second rising edge after L is first sampled.
- R3: When level_i is 0, all bits of asrt_o are low on the second rising edge after 0 is sampled.
- R4: ast_pulse_o[i] is high for exactly the one cycle after the edge on which asrt_o[i] rises, and never otherwise.
- R5: deast_pulse_o[i] is high for exactly the one cycle after the edge on which asrt_o[i] falls, and never otherwise.
- R6: en_pulse_o[i] is high together with ast_pulse_o[i] when en_zero_i[i] is high on the edge where slot i rises.
- R7: en_pulse_o[i] stays low when en_zero_i[i] is low on that edge, and is never high without ast_pulse_o[i].
- R8: While level_i is held constant, once asrt_o has settled no pulse of any kind is produced.
- R9: At no time is more than one bit of asrt_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| level_i | input | 4 | Encoded interrupt level, 0 = none, 15 = highest |
| en_zero_i | input | 15 | Per-slot flag: enable count is currently zero |
| asrt_o | output | 15 | Per-slot asserted state |
| ast_pulse_o | output | 15 | One-cycle pulse: slot became asserted |
| deast_pulse_o | output | 15 | One-cycle pulse: slot became deasserted |
| en_pulse_o | output | 15 | One-cycle pulse: enable increment for a newly asserted slot |

## Verification
A level value is captured by the first rising edge after it is driven, and asrt_o together with all three pulse vectors reflect it after the second; en_zero_i is consumed on that second edge. The bench keeps a behavioural model that applies the same two-edge lag, drives inputs on falling edges and compares every output on the falling edge, so each comparison sees the values settled by the last rising edge. Back-to-back level changes, holds, level 0 and every level value are run so that deassert and assert events overlap in the same cycle.

// File: rtl/irl_pkg.sv
package irl_pkg;
  typedef enum logic [1:0] {
    SLOT_HOLD = 2'd0,
    SLOT_SET  = 2'd1,
    SLOT_CLR  = 2'd2
  } slot_act_e;
endpackage

// File: rtl/irl_level_reg.sv
module irl_level_reg #(
  parameter int LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_o <= '0;
    else         level_o <= level_i;
  end
endmodule

// File: rtl/irl_target_dec.sv
module irl_target_dec #(
  parameter int LVL_W = 4,
  localparam int N_SRC = (1 << LVL_W) - 1
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [N_SRC-1:0] tgt_o
);
  logic [LVL_W-1:0] pos;

  // inverted level indexes the chain; level 0 lands on N_SRC, beyond the chain
  assign pos = level_i ^ {LVL_W{1'b1}};

  for (genvar g = 0; g < N_SRC; g++) begin : g_dec
    assign tgt_o[g] = (pos == LVL_W'(g));
  end
endmodule

// File: rtl/irl_src_slot.sv
module irl_src_slot
  import irl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgt_i,
  input  logic en_zero_i,
  output logic asrt_o,
  output logic ast_pulse_o,
  output logic deast_pulse_o,
  output logic en_pulse_o
);
  slot_act_e act;

  always_comb begin
    act = SLOT_HOLD;
    if (tgt_i && !asrt_o)      act = SLOT_SET;
    else if (!tgt_i && asrt_o) act = SLOT_CLR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asrt_o        <= 1'b0;
      ast_pulse_o   <= 1'b0;
      deast_pulse_o <= 1'b0;
      en_pulse_o    <= 1'b0;
    end else begin
      ast_pulse_o   <= (act == SLOT_SET);
      deast_pulse_o <= (act == SLOT_CLR);
      en_pulse_o    <= (act == SLOT_SET) && en_zero_i;
      case (act)
        SLOT_SET: asrt_o <= 1'b1;
        SLOT_CLR: asrt_o <= 1'b0;
        default:  asrt_o <= asrt_o;
      endcase
    end
  end
endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder #(
  parameter int LVL_W = 4,
  localparam int N_SRC = (1 << LVL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [N_SRC-1:0] en_zero_i,
  output logic [N_SRC-1:0] asrt_o,
  output logic [N_SRC-1:0] ast_pulse_o,
  output logic [N_SRC-1:0] deast_pulse_o,
  output logic [N_SRC-1:0] en_pulse_o
);
  logic [LVL_W-1:0] level_q;
  logic [N_SRC-1:0] tgt;

  irl_level_reg #(.LVL_W(LVL_W)) u_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level_i),
    .level_o(level_q)
  );

  irl_target_dec #(.LVL_W(LVL_W)) u_dec (
    .level_i(level_q),
    .tgt_o  (tgt)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    irl_src_slot u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tgt_i        (tgt[g]),
      .en_zero_i    (en_zero_i[g]),
      .asrt_o       (asrt_o[g]),
      .ast_pulse_o  (ast_pulse_o[g]),
      .deast_pulse_o(deast_pulse_o[g]),
      .en_pulse_o   (en_pulse_o[g])
    );
  end
endmodule

// File: rtl/irl_level_decoder_chk.sv
module irl_level_decoder_chk #(
  parameter int LVL_W = 4,
  localparam int N_SRC = (1 << LVL_W) - 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] level_i,
  input logic [N_SRC-1:0] asrt_o,
  input logic [N_SRC-1:0] ast_pulse_o,
  input logic [N_SRC-1:0] deast_pulse_o,
  input logic [N_SRC-1:0] en_pulse_o
);
  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(asrt_o));

  assert_rise_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ast_pulse_o == (asrt_o & ~$past(asrt_o))));

  assert_fall_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deast_pulse_o == (~asrt_o & $past(asrt_o))));

  assert_en_with_ast_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_pulse_o & ~ast_pulse_o) == '0));

  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(asrt_o) |-> ((ast_pulse_o | deast_pulse_o | en_pulse_o) == '0));

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(level_i, 2) == '0) |-> (asrt_o == '0));
endmodule

bind irl_level_decoder irl_level_decoder_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .level_i      (level_i),
  .asrt_o       (asrt_o),
  .ast_pulse_o  (ast_pulse_o),
  .deast_pulse_o(deast_pulse_o),
  .en_pulse_o   (en_pulse_o)
);

// File: tb/tb_irl_level_decoder.sv
`timescale 1ns/1ps
module tb_irl_level_decoder;
  localparam int LVL_W = 4;
  localparam int N_SRC = 15;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [LVL_W-1:0] level_i = '0;
  logic [N_SRC-1:0] en_zero_i = '0;
  logic [N_SRC-1:0] asrt_o, ast_pulse_o, deast_pulse_o, en_pulse_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural model state
  int          m_lvl = 0;
  bit [14:0]   m_asrt = '0, m_ap = '0, m_dp = '0, m_ep = '0;

  irl_level_decoder #(.LVL_W(LVL_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_i), .en_zero_i(en_zero_i),
    .asrt_o(asrt_o), .ast_pulse_o(ast_pulse_o),
    .deast_pulse_o(deast_pulse_o), .en_pulse_o(en_pulse_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lvl = 0; m_asrt = '0; m_ap = '0; m_dp = '0; m_ep = '0;
    end else begin
      int sel;
      sel = (m_lvl == 0) ? -1 : (m_lvl ^ 15);
      for (int i = 0; i < N_SRC; i++) begin
        bit want;
        want = (i == sel);
        m_ap[i] = want && !m_asrt[i];
        m_dp[i] = !want && m_asrt[i];
        m_ep[i] = m_ap[i] && en_zero_i[i];
        m_asrt[i] = want;
      end
      m_lvl = int'(level_i);
    end
  end

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge once running
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk((m_lvl == 0 && m_asrt == 0) ? "R3" : "R2", asrt_o, m_asrt);
      chk("R4", ast_pulse_o, m_ap);
      chk("R5", deast_pulse_o, m_dp);
      chk(m_ep != 0 ? "R6" : "R7", en_pulse_o, m_ep);
      chk("R9", 15'($countones(asrt_o) > 1), 15'd0);
    end
  end

  task automatic drive(input int lvl, input logic [14:0] ez, input int hold);
    @(negedge clk_i);
    level_i = LVL_W'(lvl);
    en_zero_i = ez;
    repeat (hold - 1) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    level_i = 4'd9;
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet in reset
    chk("R1", asrt_o | ast_pulse_o | deast_pulse_o | en_pulse_o, 15'd0);
    level_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", asrt_o | ast_pulse_o | deast_pulse_o | en_pulse_o, 15'd0);

    drive(15, 15'h0001, 4);   // R2 highest -> slot 0, R6 enable
    drive(15, 15'h7fff, 4);   // R8 hold: no pulses
    drive(1, 15'h0000, 4);    // R7 slot 14 without enable
    drive(7, 15'h0100, 3);    // slot 8 with enable
    drive(0, 15'h7fff, 4);    // R3 idle
    drive(0, 15'h0000, 3);
    for (int l = 0; l < 16; l++) drive(l, 15'(l * 1234), 1);  // back-to-back
    for (int l = 15; l >= 0; l--) drive(l, 15'h5555, 2);
    drive(8, 15'h0080, 3);
    drive(8, 15'h0080, 3);    // R8 steady while en_zero high
    drive(3, 15'h1000, 1);
    drive(0, 15'h0000, 4);
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule